// File: doc/BRIEF.md
# CCD Black-Level Correction Loop

This block keeps the black level of digitized CCD pixels at a programmed target code. In automatic mode, a black-clamp strobe marks the dummy black pixels at the start of each horizontal line. While the strobe is high, the block adds up the first eight 10-bit converter samples. When the strobe falls, it takes the average and subtracts it from the target. It then scales that error by a selectable power of two and adds the result into an 8-bit offset accumulator. The accumulator saturates at both ends and drives the offset DAC code that sits ahead of the gain stage.

Two other modes bypass the loop. In manual mode, a per-pixel 2-bit select picks one of four preloaded offset registers. Selecting the auxiliary video input always applies offset register 0. A separate control bit sends the chosen offset onto the digital data bus in place of pixel data, and the DAC code is then held at zero. The offset registers are loaded through a plain address/data/write-enable port. They can be rewritten during vertical blanking to prepare values for each line.

Top module: `blackLevelLoop`

## Requirements
- R1: While reset is asserted (`rstN` low), and after it is released, the accumulator holds 128 and all four offset registers hold 0. With automatic mode selected, `dacCode` therefore reads 128.
- R2: A sample is collected only on a clock edge where `blkStrobe` is high and `autoEnable` is 1. Only the first eight samples of a strobe pulse are used, and any further samples in the same pulse are ignored. The sample count clears while the strobe is low.
- R3: The accumulator changes only at the falling edge of `blkStrobe`, meaning the first clock edge where the strobe is low after it was high, and only if eight samples were collected in that pulse. The error is `targetCode` minus the sum of the eight samples shifted right by 3, as a signed 11-bit value.
- R4: The error is arithmetic-shifted right before accumulation, selected by `scaleSel`: 0 gives shift 0, 1 gives shift 2, 2 gives shift 3, and 3 gives shift 4.
- R5: The accumulator saturates at 0 and 255 and never wraps.
- R6: With `autoEnable` at 0, the accumulator does not change. The applied offset is then the offset register picked by `manualSel`.
- R7: In manual mode, `manualSel` picks the offset register combinationally, so each pixel can use a different register.
- R8: When `regWrEn` is 1 at a clock edge, register `regAddr` takes `regWrData`. The new value is not visible before that edge.
- R9: With `auxSelect` at 1, the applied offset is register 0, whatever the values of `autoEnable` and `manualSel`.
- R10: With `offsetToBus` at 1, `busData` carries the applied offset zero-extended to 10 bits and `dacCode` is 0. With `offsetToBus` at 0, `busData` carries `pixelData` and `dacCode` carries the applied offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkStrobe | input | 1 | Black-clamp strobe, high during the dummy black pixels |
| pixelData | input | 10 | Converter sample for the current pixel |
| targetCode | input | 10 | Desired black-level code |
| autoEnable | input | 1 | 1 selects automatic correction, 0 selects manual mode |
| scaleSel | input | 2 | Error scale (shift) select |
| offsetToBus | input | 1 | Send the offset to the data bus instead of the DAC |
| manualSel | input | 2 | Per-pixel offset register select for manual mode |
| auxSelect | input | 1 | Auxiliary input selected, forces offset register 0 |
| regWrEn | input | 1 | Offset register write enable |
| regAddr | input | 2 | Offset register write address |
| regWrData | input | 8 | Offset register write data |
| dacCode | output | 8 | Offset DAC code |
| busData | output | 10 | Digital output bus |

## Verification
The hardest cases to reach from the ports are the strobe pulses that must leave the accumulator unchanged or only partly used. One kind is a pulse shorter than eight pixels. The other is a pulse longer than eight pixels, where the late samples would change the average if they were counted. The stimulus table sets the length of each strobe pulse directly and ramps the sample values. The late samples of an over-long pulse are made very large, so counting them would visibly move the result. A line run with automatic mode off is followed by switching automatic mode back on, so the held accumulator value can be read at `dacCode`.

// File: rtl/blk_loop_pkg.sv
package blk_loop_pkg;
  typedef struct packed {
    logic sampleEn;   // add the current pixel into the black sum
    logic clearSum;   // drop the partial sum (strobe low)
    logic updateAcc;  // fold the scaled error into the offset accumulator
  } loopStrobes_t;
endpackage

// File: rtl/blkLoopCtrl.sv
module blkLoopCtrl
  import blk_loop_pkg::*;
#(
  parameter int NUM_SAMPLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         blkStrobe,
  input  logic         autoEnable,
  output loopStrobes_t strobes
);
  localparam int CNT_W = $clog2(NUM_SAMPLES + 1);

  logic [CNT_W-1:0] sampleCount;
  logic             strobeDly;
  logic             countFull;

  assign countFull = (sampleCount == CNT_W'(NUM_SAMPLES));

  always_comb begin
    strobes.sampleEn  = blkStrobe && autoEnable && !countFull;
    strobes.clearSum  = !blkStrobe;
    strobes.updateAcc = strobeDly && !blkStrobe && countFull && autoEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCount <= '0;
      strobeDly   <= 1'b0;
    end else begin
      strobeDly <= blkStrobe;
      if (!blkStrobe)
        sampleCount <= '0;
      else if (strobes.sampleEn)
        sampleCount <= sampleCount + 1'b1;
    end
  end

  AST_UPDATE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updateAcc |-> (strobeDly && !blkStrobe)) else $error("update off strobe fall"); // R3
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !blkStrobe |=> (sampleCount == '0)) else $error("count not cleared"); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    countFull && blkStrobe |=> countFull) else $error("count left limit"); // R2
endmodule

// File: rtl/blkLoopDatapath.sv
module blkLoopDatapath
  import blk_loop_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int OFS_W       = 8,
  parameter int NUM_SAMPLES = 8,
  parameter int NUM_REGS    = 4,
  parameter int ACC_RESET   = 128
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  loopStrobes_t                strobes,
  input  logic [DATA_W-1:0]           pixelData,
  input  logic [DATA_W-1:0]           targetCode,
  input  logic                        autoEnable,
  input  logic [1:0]                  scaleSel,
  input  logic                        offsetToBus,
  input  logic [$clog2(NUM_REGS)-1:0] manualSel,
  input  logic                        auxSelect,
  input  logic                        regWrEn,
  input  logic [$clog2(NUM_REGS)-1:0] regAddr,
  input  logic [OFS_W-1:0]            regWrData,
  output logic [OFS_W-1:0]            dacCode,
  output logic [DATA_W-1:0]           busData
);
  localparam int AVG_SHIFT = $clog2(NUM_SAMPLES);
  localparam int SUM_W     = DATA_W + AVG_SHIFT;
  localparam int ERR_W     = DATA_W + 1;
  localparam int SEL_W     = $clog2(NUM_REGS);
  localparam int EXT_W     = ((ERR_W > OFS_W + 1) ? ERR_W : OFS_W + 1) + 1;
  localparam int OFS_MAX   = (1 << OFS_W) - 1;

  logic [SUM_W-1:0]        sumReg;
  logic [DATA_W-1:0]       avgVal;
  logic signed [ERR_W-1:0] errVal;
  logic signed [ERR_W-1:0] scaledErr;
  logic signed [EXT_W-1:0] accSum;
  logic [OFS_W-1:0]        accNext;
  logic [OFS_W-1:0]        accReg;
  logic [OFS_W-1:0]        bankReg [NUM_REGS];
  logic [OFS_W-1:0]        offsetSel;

  // black sum over the strobe window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sumReg <= '0;
    else if (strobes.clearSum)
      sumReg <= '0;
    else if (strobes.sampleEn)
      sumReg <= sumReg + SUM_W'(pixelData);
  end

  // error, scaling and saturating accumulate
  always_comb begin
    avgVal = DATA_W'(sumReg >> AVG_SHIFT);
    errVal = $signed({1'b0, targetCode}) - $signed({1'b0, avgVal});
    case (scaleSel)
      2'd0:    scaledErr = errVal;
      2'd1:    scaledErr = errVal >>> 2;
      2'd2:    scaledErr = errVal >>> 3;
      default: scaledErr = errVal >>> 4;
    endcase
    accSum = $signed({{(EXT_W-OFS_W){1'b0}}, accReg})
           + $signed({{(EXT_W-ERR_W){scaledErr[ERR_W-1]}}, scaledErr});
    if (accSum < 0)
      accNext = '0;
    else if (accSum > $signed(EXT_W'(OFS_MAX)))
      accNext = OFS_W'(OFS_MAX);
    else
      accNext = accSum[OFS_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      accReg <= OFS_W'(ACC_RESET);
    else if (strobes.updateAcc)
      accReg <= accNext;
  end

  // manual offset bank
  for (genvar g = 0; g < NUM_REGS; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bankReg[g] <= '0;
      else if (regWrEn && (regAddr == SEL_W'(g)))
        bankReg[g] <= regWrData;
    end

    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      regWrEn && (regAddr == SEL_W'(g)) |=> bankReg[g] == $past(regWrData))
      else $error("bank write lost"); // R8
  end

  // offset source and output routing
  always_comb begin
    if (auxSelect)
      offsetSel = bankReg[0];
    else if (autoEnable)
      offsetSel = accReg;
    else
      offsetSel = bankReg[manualSel];
    dacCode = offsetToBus ? '0 : offsetSel;
    busData = offsetToBus ? DATA_W'(offsetSel) : pixelData;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.updateAcc |=> $stable(accReg)) else $error("acc moved"); // R6
  AST_SAT_UP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updateAcc && !scaledErr[ERR_W-1] |=> accReg >= $past(accReg))
    else $error("acc wrapped down"); // R5
  AST_SAT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updateAcc && scaledErr[ERR_W-1] |=> accReg <= $past(accReg))
    else $error("acc wrapped up"); // R5
endmodule

// File: rtl/blackLevelLoop.sv
module blackLevelLoop
  import blk_loop_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int OFS_W       = 8,
  parameter int NUM_SAMPLES = 8,
  parameter int NUM_REGS    = 4,
  parameter int ACC_RESET   = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        blkStrobe,
  input  logic [9:0]  pixelData,
  input  logic [9:0]  targetCode,
  input  logic        autoEnable,
  input  logic [1:0]  scaleSel,
  input  logic        offsetToBus,
  input  logic [1:0]  manualSel,
  input  logic        auxSelect,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  dacCode,
  output logic [9:0]  busData
);
  loopStrobes_t strobes;

  blkLoopCtrl #(.NUM_SAMPLES(NUM_SAMPLES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .blkStrobe  (blkStrobe),
    .autoEnable (autoEnable),
    .strobes    (strobes)
  );

  blkLoopDatapath #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .NUM_SAMPLES(NUM_SAMPLES),
    .NUM_REGS(NUM_REGS), .ACC_RESET(ACC_RESET)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pixelData   (pixelData),
    .targetCode  (targetCode),
    .autoEnable  (autoEnable),
    .scaleSel    (scaleSel),
    .offsetToBus (offsetToBus),
    .manualSel   (manualSel),
    .auxSelect   (auxSelect),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .dacCode     (dacCode),
    .busData     (busData)
  );

  AST_BUS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    offsetToBus |-> (dacCode == '0) && (busData[9:8] == 2'b00))
    else $error("bus routing"); // R10
endmodule

// File: tb/tb_blackLevelLoop.sv
`timescale 1ns/1ps
module tb_blackLevelLoop;
  logic       clk = 1'b0;
  logic       rstN;
  logic       blkStrobe;
  logic [9:0] pixelData;
  logic [9:0] targetCode;
  logic       autoEnable;
  logic [1:0] scaleSel;
  logic       offsetToBus;
  logic [1:0] manualSel;
  logic       auxSelect;
  logic       regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] dacCode;
  logic [9:0] busData;

  int checks = 0;
  int fails  = 0;
  int modelAcc = 128;
  int bankVal [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  blackLevelLoop dut (
    .clk(clk), .rstN(rstN), .blkStrobe(blkStrobe), .pixelData(pixelData),
    .targetCode(targetCode), .autoEnable(autoEnable), .scaleSel(scaleSel),
    .offsetToBus(offsetToBus), .manualSel(manualSel), .auxSelect(auxSelect),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .dacCode(dacCode), .busData(busData)
  );

  // columns: first sample, sample step, target, scale select, pulse length
  localparam int NROWS = 10;
  localparam int LINES [NROWS][5] = '{
    '{  64,   0,   64, 0,  8},
    '{  60,   0,   64, 0,  8},
    '{ 100,   2,   64, 1,  8},
    '{   0,   0,  900, 0,  5},
    '{   0, 100,  512, 2, 11},
    '{   0,   0, 1023, 0,  8},
    '{1023,   0,    0, 0,  8},
    '{   0,   0,  160, 3,  8},
    '{  10,   0,    0, 3,  8},
    '{  20,   3,  300, 2,  8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one black strobe pulse; reference model follows the requirements
  task automatic runLine(input int base, input int step, input int tgt,
                         input int sc, input int n);
    int sum = 0;
    int err;
    int shAmt;
    @(negedge clk);
    targetCode = 10'(tgt);
    scaleSel   = 2'(sc);
    for (int i = 0; i < n; i++) begin
      blkStrobe = 1'b1;
      pixelData = 10'(base + i * step);
      if (i < 8) sum += base + i * step;
      @(negedge clk);
    end
    blkStrobe = 1'b0;
    @(negedge clk);
    if (autoEnable && n >= 8) begin
      err   = tgt - (sum >> 3);
      shAmt = (sc == 0) ? 0 : (sc == 1) ? 2 : (sc == 2) ? 3 : 4;
      modelAcc = modelAcc + (err >>> shAmt);
      if (modelAcc < 0)   modelAcc = 0;
      if (modelAcc > 255) modelAcc = 255;
    end
  endtask

  task automatic writeReg(input int addr, input int val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(addr); regWrData = 8'(val);
    manualSel = 2'(addr);
    #1 chk("R8 before edge", int'(dacCode), bankVal[addr]);
    @(negedge clk);
    regWrEn = 1'b0;
    bankVal[addr] = val;
    #1 chk("R8 after edge", int'(dacCode), val);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; blkStrobe = 1'b0; pixelData = 10'd333; targetCode = '0;
    autoEnable = 1'b1; scaleSel = '0; offsetToBus = 1'b0; manualSel = '0;
    auxSelect = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset dac", int'(dacCode), 128);
    chk("R10 bus passthrough", int'(busData), 333);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(dacCode), 128);

    // automatic mode vectors: R2 R3 R4 R5
    for (int r = 0; r < NROWS; r++) begin
      runLine(LINES[r][0], LINES[r][1], LINES[r][2], LINES[r][3], LINES[r][4]);
      chk($sformatf("R3/R4/R5/R2 line %0d", r), int'(dacCode), modelAcc);
    end

    // manual bank: R8 writes then R7 per-pixel select
    autoEnable = 1'b0;
    for (int a = 0; a < 4; a++) writeReg(a, a * 40 + 17);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      manualSel = 2'((p * 3) % 4);
      #1 chk("R7 manual select", int'(dacCode), bankVal[(p * 3) % 4]);
    end

    // R6: a line with auto off leaves the accumulator untouched
    runLine(0, 0, 1023, 0, 8);
    manualSel = 2'd2;
    #1 chk("R6 manual offset", int'(dacCode), bankVal[2]);
    autoEnable = 1'b1;
    #1 chk("R6 acc held", int'(dacCode), modelAcc);

    // R9: aux forces register 0
    auxSelect = 1'b1; manualSel = 2'd3;
    #1 chk("R9 aux with auto", int'(dacCode), bankVal[0]);
    autoEnable = 1'b0;
    #1 chk("R9 aux with manual", int'(dacCode), bankVal[0]);
    auxSelect = 1'b0; autoEnable = 1'b1;

    // R10: offset onto the bus
    @(negedge clk);
    pixelData = 10'd777; offsetToBus = 1'b1;
    #1 chk("R10 bus offset", int'(busData), modelAcc);
    chk("R10 dac zero", int'(dacCode), 0);
    offsetToBus = 1'b0;
    #1 chk("R10 bus pixel", int'(busData), 777);
    chk("R10 dac offset", int'(dacCode), modelAcc);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule